// File: doc/BRIEF.md
# Saturating Tuning-Word Counter

This block keeps the digital code that sets the characteristic frequency of a programmable analog filter. A phase comparator elsewhere compares the filter output with a matched delay path. When the filter leads it sends a pulse on the down line. When the filter lags it sends a pulse on the up line. Each pulse moves the code by one toward the correct setting. The block counts only while its enable input is high. The code starts just below midscale, so the search can move either way. At both ends of the range the code clamps. It never jumps from one end to the other.

Both pulse lines pass through a synchronizer. A pulse is detected by its rising edge in the system-clock domain, so a pulse several clocks wide still takes exactly one step. If an up edge and a down edge are seen in the same clock, the code holds. A quiet timer counts reference-cycle ticks that arrive with no correction. After a programmable number of such ticks it raises a settled flag, which tells the rest of the chip that the loop has locked.

Top module: `tune_word_ctr`

## Requirements
- R1: While reset is asserted and in the cycle after it releases, the code equals 2^(WORD_W-1)-1 (7 for the default width of 4) and the settled flag is low.
- R2: A rising edge on the up line with enable high, and no down edge in the same clock, raises the code by exactly one.
- R3: A rising edge on the down line with enable high, and no up edge in the same clock, lowers the code by exactly one.
- R4: An up step at the top code (15 by default) and a down step at code 0 are suppressed. The code never wraps between 0 and the top code.
- R5: While enable is low, edges on either pulse line leave the code unchanged.
- R6: A pulse held high for several clocks takes one step only, and the code changes by at most one per clock.
- R7: If up and down rising edges reach the counter in the same clock, the code is unchanged.
- R8: The settled flag rises on the reference tick that completes settle_len quiet ticks counted since the last correction or reset. A settle_len of 0 behaves like 1.
- R9: Any enabled rising edge on either pulse line counts as a correction, including a suppressed or coincident one. A correction clears the settled flag in the following cycle and restarts the quiet count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable |
| up_pulse | input | 1 | Raise-code correction pulse from the phase comparator |
| dn_pulse | input | 1 | Lower-code correction pulse from the phase comparator |
| ref_tick | input | 1 | One-clock strobe, once per reference cycle |
| settle_len | input | SETTLE_W | Number of quiet reference ticks required before the settled flag rises |
| tune_code | output | WORD_W | Tuning word for the filter |
| settled | output | 1 | Loop has seen settle_len quiet ticks |

## Verification
The checker examines every clock. It confirms that the code never wraps, moves by at most one per cycle, holds while enable is low or when the two edges coincide, and that a lone enabled up edge below the top code raises it by one. It also confirms that the code leaves reset at just below midscale and that any correction drops the settled flag. Some behaviour can only be shown by the bench's scenarios, because it depends on pulse history and tick counting. This covers one step per wide pulse, the exact tick on which the settled flag rises for a given settle_len, and the treatment of a length of zero.

// File: rtl/tune_ctr_pkg.sv
package tune_ctr_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Turn the two edge events and the enable into one step request.
  function automatic step_e decode_step(input logic enable,
                                        input logic up_evt,
                                        input logic dn_evt);
    step_e s;
    if (!enable || (up_evt && dn_evt)) s = STEP_HOLD;
    else if (up_evt)                   s = STEP_UP;
    else if (dn_evt)                   s = STEP_DN;
    else                               s = STEP_HOLD;
    return s;
  endfunction

endpackage

// File: rtl/tctr_edge_sync.sv
module tctr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];

  assign rise = chain[LAST] & ~prev;

endmodule

// File: rtl/tctr_sat_counter.sv
module tctr_sat_counter
  import tune_ctr_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             step,
  output logic [WORD_W-1:0] code
);
  localparam logic [WORD_W-1:0] CODE_MAX = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] CODE_MID = {1'b0, {(WORD_W-1){1'b1}}};

  // Next code with clamping at both ends.
  function automatic logic [WORD_W-1:0] clamp_step(input logic [WORD_W-1:0] cur,
                                                   input step_e s);
    logic [WORD_W-1:0] nxt;
    nxt = cur;
    case (s)
      STEP_UP: if (cur != CODE_MAX) nxt = cur + 1'b1;
      STEP_DN: if (cur != '0)       nxt = cur - 1'b1;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) code <= CODE_MID;
    else        code <= clamp_step(code, step);

endmodule

// File: rtl/tctr_quiet_timer.sv
module tctr_quiet_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                correction,
  input  logic                tick,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                settled
);
  logic [SETTLE_W-1:0] quiet_cnt;
  logic [SETTLE_W:0]   quiet_nxt;
  logic                reach;

  function automatic logic hits_len(input logic [SETTLE_W:0] n,
                                    input logic [SETTLE_W-1:0] len);
    return n >= {1'b0, len};
  endfunction

  assign quiet_nxt = {1'b0, quiet_cnt} + 1'b1;
  assign reach     = hits_len(quiet_nxt, settle_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_cnt <= '0;
      settled   <= 1'b0;
    end else if (correction) begin
      quiet_cnt <= '0;
      settled   <= 1'b0;
    end else if (tick && !settled) begin
      if (reach) settled <= 1'b1;
      else       quiet_cnt <= quiet_nxt[SETTLE_W-1:0];
    end
  end

endmodule

// File: rtl/tune_word_ctr.sv
module tune_word_ctr
  import tune_ctr_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                up_pulse,
  input  logic                dn_pulse,
  input  logic                ref_tick,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [WORD_W-1:0]   tune_code,
  output logic                settled
);
  logic  up_rise;
  logic  dn_rise;
  logic  correction;
  step_e step;

  tctr_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst_n(rst_n), .din(up_pulse), .rise(up_rise)
  );

  tctr_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst_n(rst_n), .din(dn_pulse), .rise(dn_rise)
  );

  assign step       = decode_step(en, up_rise, dn_rise);
  assign correction = en & (up_rise | dn_rise);

  tctr_sat_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .code(tune_code)
  );

  tctr_quiet_timer #(.SETTLE_W(SETTLE_W)) u_quiet (
    .clk(clk), .rst_n(rst_n), .correction(correction), .tick(ref_tick),
    .settle_len(settle_len), .settled(settled)
  );

endmodule

// File: rtl/tune_word_ctr_chk.sv
module tune_word_ctr_chk #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              up_rise,
  input logic              dn_rise,
  input logic [WORD_W-1:0] tune_code,
  input logic              settled
);
  localparam logic [WORD_W-1:0] CMAX = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] CMID = {1'b0, {(WORD_W-1){1'b1}}};

  a_r1_reset_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tune_code == CMID && !settled));

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up_rise && !dn_rise && tune_code != CMAX)
      |=> tune_code == WORD_W'($past(tune_code) + 1'b1));

  a_r4_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_code == CMAX) |=> (tune_code != '0));

  a_r4_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_code == '0) |=> (tune_code != CMAX));

  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(tune_code));

  a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(tune_code)
              || tune_code == WORD_W'($past(tune_code) + 1'b1)
              || tune_code == WORD_W'($past(tune_code) - 1'b1)));

  a_r7_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rise && dn_rise) |=> $stable(tune_code));

  a_r9_clear_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (up_rise || dn_rise)) |=> !settled);

endmodule

bind tune_word_ctr tune_word_ctr_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .up_rise(up_rise), .dn_rise(dn_rise),
  .tune_code(tune_code), .settled(settled)
);

// File: tb/tune_word_ctr_bench.sv
module tune_word_ctr_bench;
  localparam int W  = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          up_pulse = 1'b0;
  logic          dn_pulse = 1'b0;
  logic          ref_tick = 1'b0;
  logic [SW-1:0] settle_len = '0;
  logic [W-1:0]  tune_code;
  logic          settled;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int exp_code;

  always #4 clk = ~clk;

  tune_word_ctr u_tune_word_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .ref_tick(ref_tick), .settle_len(settle_len), .tune_code(tune_code),
    .settled(settled)
  );

  // Bench's own model of one correction.
  function automatic int model_step(int cur, bit e, bit u, bit d);
    int top = (1 << W) - 1;
    if (!e || (u && d)) return cur;
    if (u) return (cur < top) ? cur + 1 : cur;
    if (d) return (cur > 0) ? cur - 1 : cur;
    return cur;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit e, bit u, bit d, int width);
    @(negedge clk);
    en = e; up_pulse = u; dn_pulse = d;
    repeat (width) @(negedge clk);
    up_pulse = 1'b0; dn_pulse = 1'b0;
    repeat (6) @(negedge clk);
    exp_code = model_step(exp_code, e, u, d);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_code = (1 << (W - 1)) - 1;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(tune_code), 7);
    check("R1 reset settled", int'(settled), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(tune_code), 7);

    pulse(1, 1, 0, 1);
    check("R2 up step", int'(tune_code), 8);
    pulse(1, 0, 1, 1);
    check("R3 down step", int'(tune_code), 7);
    pulse(1, 1, 0, 5);
    check("R6 wide pulse one step", int'(tune_code), 8);
    pulse(0, 1, 0, 1);
    check("R5 disabled up ignored", int'(tune_code), 8);
    pulse(0, 0, 1, 3);
    check("R5 disabled down ignored", int'(tune_code), 8);
    pulse(1, 1, 1, 2);
    check("R7 coincident hold", int'(tune_code), 8);

    for (int i = 0; i < 12; i++) pulse(1, 1, 0, 1);
    check("R4 saturate top", int'(tune_code), 15);
    pulse(1, 1, 0, 1);
    check("R4 no wrap at top", int'(tune_code), 15);
    for (int i = 0; i < 20; i++) pulse(1, 0, 1, 2);
    check("R4 saturate bottom", int'(tune_code), 0);
    pulse(1, 0, 1, 1);
    check("R4 no wrap at bottom", int'(tune_code), 0);

    // Settle: correction at bottom still counts (R9), then 5 quiet ticks.
    settle_len = 8'd5;
    pulse(1, 0, 1, 1);
    ticks(4);
    check("R8 not yet settled", int'(settled), 0);
    ticks(1);
    check("R8 settled after len ticks", int'(settled), 1);
    pulse(1, 1, 0, 1);
    check("R9 correction clears", int'(settled), 0);
    check("R2 up from 0", int'(tune_code), exp_code);
    ticks(4);
    check("R9 count restarted", int'(settled), 0);
    ticks(1);
    check("R9 settles again", int'(settled), 1);
    pulse(1, 1, 1, 1);
    check("R9 coincident is correction", int'(settled), 0);
    settle_len = 8'd0;
    ticks(1);
    check("R8 zero length one tick", int'(settled), 1);

    // Random mix.
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 300; i++) begin
      bit e = ($urandom % 4) != 0;
      bit u = $urandom % 2;
      bit d = $urandom % 2;
      int w = 1 + ($urandom % 4);
      pulse(e, u, d, w);
      check("R2 R3 R4 R5 R7 random", int'(tune_code), exp_code);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule